// File: doc/BRIEF.md
# Effective Address Generator with Pointer Fetch

This block turns an addressing-mode code, an operand and the two index registers into a 16-bit effective address for a load, store or jump. Direct modes (zero page, zero page indexed by X or Y, absolute) are resolved arithmetically and reported one cycle after the request. Zero-page indexing wraps within the low byte, so the result never leaves page zero.

Indirect modes need a pointer held in memory. The block issues two byte reads on a synchronous memory port, low byte first and then high byte, and assembles the little-endian pointer as the result. The pointer location comes from an 8-bit zero-page operand, from a 16-bit operand, or from a 16-bit operand plus X using a full 16-bit sum. A mode code outside the supported set completes at once with an error flag.

A request is a one-cycle `start` pulse. While an indirect fetch is in flight, further requests are dropped. The result and the error flag hold their values until the next completion.

Top module: `eff_addr_unit`

## Requirements
- R1: Mode code 0 (zero page) yields {8'h00, operand[7:0]} with no memory read.
- R2: Mode code 1 (zero page X) yields {8'h00, (operand[7:0] + X) mod 256}, so the high byte is always zero.
- R3: Mode code 2 (zero page Y) yields {8'h00, (operand[7:0] + Y) mod 256}, so the high byte is always zero.
- R4: Mode code 3 (absolute) yields the 16-bit operand unchanged with no memory read.
- R5: Mode code 4 (zero-page indirect) reads the low byte at {8'h00, operand[7:0]} and the high byte at {8'h00, (operand[7:0] + 1) mod 256}, and yields {high, low}.
- R6: Mode code 5 (indirect) reads the low byte at the 16-bit operand and the high byte at (operand + 1) mod 65536, and yields {high, low}.
- R7: Mode code 6 (absolute X indirect) forms the pointer address as (operand + X) mod 65536, reads the low byte there and the high byte at the next address, and yields {high, low}.
- R8: When `start` is sampled with the unit idle, a direct or unsupported mode raises `done` for one cycle in the next cycle. An indirect mode drives `mem_rd` in the two cycles after the start edge (low address, then high address). Read data is taken one cycle after each request. `done` rises in the fourth cycle after the start edge.
- R9: Mode code 7 completes as a direct mode does, with `err` = 1, `addr_out` = 0 and no memory read. Every supported-mode completion leaves `err` = 0.
- R10: A `start` pulse that arrives while an indirect fetch is in progress is dropped. It changes neither the result nor the memory traffic.
- R11: `addr_out` and `err` change only in a cycle in which `done` is high. Between completions they hold their values.
- R12: During and right after reset, `done`, `err`, `mem_rd` and `addr_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe |
| mode | input | 3 | Addressing-mode code (0..7) |
| operand | input | 16 | Operand; zero-page modes use bits 7:0 |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| mem_rd | output | 1 | Memory byte read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, valid one cycle after the request |
| done | output | 1 | Result valid pulse |
| addr_out | output | 16 | Effective address, held between completions |
| err | output | 1 | Unsupported mode flag, held with the result |

## Verification
The checker assumes that the memory returns data exactly one cycle after each `mem_rd`. It also assumes that `mode`, `operand` and the index registers are stable in the cycle `start` is sampled. The bench memory model answers every request on the next edge with a byte computed from the address. The bench drives requests only at falling edges, holding all fields for the whole cycle. Overlapping requests are issued only in the deliberate busy-drop test. There the checker's pairing rules for reads still hold, because the dropped request never reaches the sequencer.

// File: rtl/eau_pkg.sv
package eau_pkg;
   typedef enum logic [2:0] {
      AM_ZP     = 3'd0,
      AM_ZPX    = 3'd1,
      AM_ZPY    = 3'd2,
      AM_ABS    = 3'd3,
      AM_IZP    = 3'd4,
      AM_IABS   = 3'd5,
      AM_IABSX  = 3'd6,
      AM_BAD    = 3'd7
   } am_e;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_LO   = 2'd1,
      SEQ_HI   = 2'd2,
      SEQ_CAP  = 2'd3
   } seq_e;

   localparam int MODE_W = 3;
endpackage

// File: rtl/eau_mode_decode.sv
module eau_mode_decode
   import eau_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter bit ZP_WRAP = 1'b1
) (
   input  logic [MODE_W-1:0] mode,
   input  logic [ADDR_W-1:0] operand,
   input  logic [DATA_W-1:0] idx_x,
   input  logic [DATA_W-1:0] idx_y,
   output logic [ADDR_W-1:0] dir_addr,
   output logic [ADDR_W-1:0] ptr_lo,
   output logic [ADDR_W-1:0] ptr_hi,
   output logic              is_ind,
   output logic              is_bad
);
   localparam int PG_W = ADDR_W - DATA_W;

   logic [DATA_W-1:0] zp_off;
   logic [DATA_W-1:0] zp_x;
   logic [DATA_W-1:0] zp_y;
   logic [ADDR_W-1:0] abs_x;
   logic [ADDR_W-1:0] lin_next;
   logic              zp_ptr;

   assign zp_off   = operand[DATA_W-1:0];
   assign zp_x     = zp_off + idx_x;
   assign zp_y     = zp_off + idx_y;
   assign abs_x    = operand + {{PG_W{1'b0}}, idx_x};
   assign lin_next = ptr_lo + ADDR_W'(1);

   always_comb begin
      dir_addr = '0;
      ptr_lo   = '0;
      is_ind   = 1'b0;
      is_bad   = 1'b0;
      zp_ptr   = 1'b0;
      case (am_e'(mode))
         AM_ZP:    dir_addr = {{PG_W{1'b0}}, zp_off};
         AM_ZPX:   dir_addr = {{PG_W{1'b0}}, zp_x};
         AM_ZPY:   dir_addr = {{PG_W{1'b0}}, zp_y};
         AM_ABS:   dir_addr = operand;
         AM_IZP: begin
            is_ind = 1'b1;
            zp_ptr = 1'b1;
            ptr_lo = {{PG_W{1'b0}}, zp_off};
         end
         AM_IABS: begin
            is_ind = 1'b1;
            ptr_lo = operand;
         end
         AM_IABSX: begin
            is_ind = 1'b1;
            ptr_lo = abs_x;
         end
         default:  is_bad = 1'b1;
      endcase
   end

   generate
      if (ZP_WRAP) begin : g_zp_wrap
         logic [DATA_W-1:0] zp_next;
         assign zp_next = ptr_lo[DATA_W-1:0] + DATA_W'(1);
         assign ptr_hi  = zp_ptr ? {{PG_W{1'b0}}, zp_next} : lin_next;
      end else begin : g_zp_linear
         assign ptr_hi = lin_next;
      end
   endgenerate
endmodule

// File: rtl/eau_ptr_seq.sv
module eau_ptr_seq
   import eau_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic [ADDR_W-1:0] lo_addr,
   input  logic [ADDR_W-1:0] hi_addr,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic              fin,
   output logic [ADDR_W-1:0] fin_addr
);
   seq_e              state;
   logic [ADDR_W-1:0] lo_q;
   logic [ADDR_W-1:0] hi_q;
   logic [DATA_W-1:0] byte_lo;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= SEQ_IDLE;
         lo_q    <= '0;
         hi_q    <= '0;
         byte_lo <= '0;
      end else begin
         case (state)
            SEQ_IDLE: if (launch) begin
               lo_q  <= lo_addr;
               hi_q  <= hi_addr;
               state <= SEQ_LO;
            end
            SEQ_LO:   state <= SEQ_HI;
            SEQ_HI: begin
               byte_lo <= mem_rdata;
               state   <= SEQ_CAP;
            end
            default:  state <= SEQ_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_rd   = 1'b0;
      mem_addr = '0;
      case (state)
         SEQ_LO: begin
            mem_rd   = 1'b1;
            mem_addr = lo_q;
         end
         SEQ_HI: begin
            mem_rd   = 1'b1;
            mem_addr = hi_q;
         end
         default: ;
      endcase
   end

   assign busy     = (state != SEQ_IDLE);
   assign fin      = (state == SEQ_CAP);
   assign fin_addr = {mem_rdata, byte_lo};
endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
   import eau_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter int IDX_W   = 8,
   parameter bit ZP_WRAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [MODE_W-1:0] mode,
   input  logic [ADDR_W-1:0] operand,
   input  logic [IDX_W-1:0]  idx_x,
   input  logic [IDX_W-1:0]  idx_y,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              done,
   output logic [ADDR_W-1:0] addr_out,
   output logic              err
);
   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_addr_w
         $error("eff_addr_unit: ADDR_W must be twice DATA_W");
      end
      if (IDX_W != DATA_W) begin : g_bad_idx_w
         $error("eff_addr_unit: IDX_W must equal DATA_W");
      end
   endgenerate

   logic [ADDR_W-1:0] dir_addr;
   logic [ADDR_W-1:0] ptr_lo;
   logic [ADDR_W-1:0] ptr_hi;
   logic              is_ind;
   logic              is_bad;
   logic              busy;
   logic              fin;
   logic [ADDR_W-1:0] fin_addr;
   logic              accept;

   eau_mode_decode #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .ZP_WRAP(ZP_WRAP)
   ) u_dec (
      .mode    (mode),
      .operand (operand),
      .idx_x   (idx_x),
      .idx_y   (idx_y),
      .dir_addr(dir_addr),
      .ptr_lo  (ptr_lo),
      .ptr_hi  (ptr_hi),
      .is_ind  (is_ind),
      .is_bad  (is_bad)
   );

   assign accept = start && !busy;

   eau_ptr_seq #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (accept && is_ind),
      .lo_addr  (ptr_lo),
      .hi_addr  (ptr_hi),
      .mem_rd   (mem_rd),
      .mem_addr (mem_addr),
      .mem_rdata(mem_rdata),
      .busy     (busy),
      .fin      (fin),
      .fin_addr (fin_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done     <= 1'b0;
         addr_out <= '0;
         err      <= 1'b0;
      end else if (accept && !is_ind) begin
         done     <= 1'b1;
         addr_out <= is_bad ? '0 : dir_addr;
         err      <= is_bad;
      end else if (fin) begin
         done     <= 1'b1;
         addr_out <= fin_addr;
         err      <= 1'b0;
      end else begin
         done     <= 1'b0;
      end
   end
endmodule

// File: rtl/eau_chk.sv
module eau_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [2:0]        mode,
   input logic              busy,
   input logic              mem_rd,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              done,
   input logic [ADDR_W-1:0] addr_out,
   input logic              err
);
   localparam int PG_W = ADDR_W - DATA_W;
   localparam logic [ADDR_W-1:0] ZP_TOP = {{PG_W{1'b0}}, {DATA_W{1'b1}}};

   AST_ZPX_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && mode == 3'd1) |=> (done && !err && addr_out[ADDR_W-1:DATA_W] == '0)); // R2

   AST_ZPY_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && mode == 3'd2) |=> (done && !err && addr_out[ADDR_W-1:DATA_W] == '0)); // R3

   AST_BAD_MODE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && mode == 3'd7) |=> (done && err && addr_out == '0)); // R9

   AST_READ_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_rd) |=> mem_rd); // R8

   AST_READ_END: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && $past(mem_rd)) |=> !mem_rd); // R8

   AST_NO_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !done); // R8

   AST_HI_FOLLOWS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && $past(mem_rd)) |->
         (mem_addr == $past(mem_addr) + ADDR_W'(1) ||
          ($past(mem_addr) == ZP_TOP && mem_addr == '0))); // R6

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(addr_out) && $stable(err))); // R11
endmodule

bind eff_addr_unit eau_chk #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .mode    (mode),
   .busy    (busy),
   .mem_rd  (mem_rd),
   .mem_addr(mem_addr),
   .done    (done),
   .addr_out(addr_out),
   .err     (err)
);

// File: tb/sim_eff_addr_unit.sv
`timescale 1ns/100ps
module sim_eff_addr_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  mode = 3'd0;
   logic [15:0] operand = 16'h0;
   logic [7:0]  idx_x = 8'h0;
   logic [7:0]  idx_y = 8'h0;
   logic        mem_rd;
   logic [15:0] mem_addr;
   logic [7:0]  mem_rdata = 8'h0;
   logic        done;
   logic [15:0] addr_out;
   logic        err;

   int n_chk = 0;
   int n_err = 0;
   int rd_cnt = 0;
   logic [15:0] prev_ra = 16'h0;
   logic [15:0] last_ra = 16'h0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   eff_addr_unit u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .operand(operand),
      .idx_x(idx_x), .idx_y(idx_y), .mem_rd(mem_rd), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .done(done), .addr_out(addr_out), .err(err)
   );

   function automatic logic [7:0] memf(input logic [15:0] a);
      return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'h3C;
   endfunction

   always @(posedge clk) begin
      if (mem_rd) begin
         mem_rdata <= memf(mem_addr);
         rd_cnt    <= rd_cnt + 1;
         prev_ra   <= last_ra;
         last_ra   <= mem_addr;
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic run(input logic [2:0] m, input logic [15:0] op, input logic [7:0] x,
                      input logic [7:0] y, output logic [15:0] a, output logic e,
                      output int lat, output int nrd, output logic [15:0] r0,
                      output logic [15:0] r1);
      int base;
      base = rd_cnt;
      @(negedge clk);
      start = 1'b1; mode = m; operand = op; idx_x = x; idx_y = y;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 12) begin
         @(negedge clk);
         lat++;
      end
      a = addr_out; e = err; nrd = rd_cnt - base; r0 = prev_ra; r1 = last_ra;
   endtask

   task automatic do_direct(input logic [2:0] m, input logic [15:0] op,
                            input logic [7:0] x, input logic [7:0] y, input string tag);
      logic [15:0] a, r0, r1, exp;
      logic e;
      int lat, nrd;
      case (m)
         3'd0: exp = {8'h00, op[7:0]};
         3'd1: exp = {8'h00, 8'(op[7:0] + x)};
         3'd2: exp = {8'h00, 8'(op[7:0] + y)};
         default: exp = op;
      endcase
      run(m, op, x, y, a, e, lat, nrd, r0, r1);
      chk({tag, " addr"}, 32'(a), 32'(exp));
      chk({tag, " err R9"}, 32'(e), 32'd0);
      chk({tag, " latency R8"}, 32'(lat), 32'd1);
      chk({tag, " no reads"}, 32'(nrd), 32'd0);
   endtask

   task automatic do_ind(input logic [2:0] m, input logic [15:0] op,
                         input logic [7:0] x, input string tag);
      logic [15:0] a, r0, r1, plo, phi;
      logic e;
      int lat, nrd;
      case (m)
         3'd4: begin
            plo = {8'h00, op[7:0]};
            phi = {8'h00, 8'(op[7:0] + 8'd1)};
         end
         3'd5: begin
            plo = op;
            phi = op + 16'd1;
         end
         default: begin
            plo = op + {8'h00, x};
            phi = plo + 16'd1;
         end
      endcase
      run(m, op, x, 8'h00, a, e, lat, nrd, r0, r1);
      chk({tag, " addr"}, 32'(a), 32'({memf(phi), memf(plo)}));
      chk({tag, " lo read addr"}, 32'(r0), 32'(plo));
      chk({tag, " hi read addr"}, 32'(r1), 32'(phi));
      chk({tag, " two reads R8"}, 32'(nrd), 32'd2);
      chk({tag, " latency R8"}, 32'(lat), 32'd4);
      chk({tag, " err R9"}, 32'(e), 32'd0);
   endtask

   initial begin
      logic [15:0] a, r0, r1, hold_a;
      logic e;
      int lat, nrd, base;
      repeat (3) @(negedge clk);
      chk("R12 reset done", 32'(done), 32'd0);
      chk("R12 reset err", 32'(err), 32'd0);
      chk("R12 reset mem_rd", 32'(mem_rd), 32'd0);
      chk("R12 reset addr_out", 32'(addr_out), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 post-reset done", 32'(done), 32'd0);
      chk("R12 post-reset addr_out", 32'(addr_out), 32'd0);

      for (int i = 0; i < 16; i++) begin
         for (int j = 0; j < 16; j++) begin
            do_direct(3'd0, 16'(i * 16'h1D3 + j), 8'(j * 17), 8'(i * 13), "R1 zp");
            do_direct(3'd1, 16'(i * 16'h0F1 + 16'h0800), 8'(j * 17), 8'(i), "R2 zpx");
            do_direct(3'd2, 16'(i * 16'h0F1 + 16'h4300), 8'(i), 8'(j * 17), "R3 zpy");
         end
         do_direct(3'd3, 16'(i * 16'h1111 + 16'h0F), 8'hFF, 8'hFF, "R4 abs");
      end
      do_direct(3'd1, 16'h12FF, 8'hFF, 8'h00, "R2 zpx wrap");
      do_direct(3'd2, 16'h0080, 8'h00, 8'h80, "R3 zpy wrap");

      for (int i = 0; i < 24; i++) begin
         do_ind(3'd4, 16'(i * 16'h0B + 16'h3300), 8'h00, "R5 zp indirect");
         do_ind(3'd5, 16'(i * 16'h0A3D), 8'h00, "R6 indirect");
         for (int j = 0; j < 4; j++)
            do_ind(3'd6, 16'(i * 16'h0A3D + 16'h00C0), 8'(j * 85), "R7 abs-x indirect");
      end
      do_ind(3'd4, 16'h00FF, 8'h00, "R5 zp pointer wrap");
      do_ind(3'd5, 16'h00FF, 8'h00, "R6 page carry");
      do_ind(3'd5, 16'hFFFF, 8'h00, "R6 top wrap");
      do_ind(3'd6, 16'hFFF0, 8'h20, "R7 16-bit wrap");
      do_ind(3'd6, 16'h01F0, 8'h20, "R7 carry into high byte");

      for (int i = 0; i < 8; i++) begin
         run(3'd7, 16'(i * 16'h2345), 8'(i), 8'(i), a, e, lat, nrd, r0, r1);
         chk("R9 bad mode err", 32'(e), 32'd1);
         chk("R9 bad mode addr", 32'(a), 32'd0);
         chk("R9 bad mode latency", 32'(lat), 32'd1);
         chk("R9 bad mode no reads", 32'(nrd), 32'd0);
      end
      do_direct(3'd3, 16'hBEEF, 8'h00, 8'h00, "R9 err clears");

      // R10: a second start during an indirect fetch is dropped
      base = rd_cnt;
      @(negedge clk);
      start = 1'b1; mode = 3'd5; operand = 16'h1234;
      @(negedge clk);
      mode = 3'd0; operand = 16'h0055;
      @(negedge clk);
      start = 1'b0;
      lat = 2;
      while (!done && lat < 12) begin
         @(negedge clk);
         lat++;
      end
      chk("R10 busy start dropped addr", 32'(addr_out), 32'({memf(16'h1235), memf(16'h1234)}));
      chk("R10 busy start latency", 32'(lat), 32'd4);
      chk("R10 busy start reads", 32'(rd_cnt - base), 32'd2);
      hold_a = addr_out;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk("R10 no extra done", 32'(done), 32'd0);
         chk("R11 addr held", 32'(addr_out), 32'(hold_a));
         chk("R11 err held", 32'(err), 32'd0);
      end

      run(3'd7, 16'h0000, 8'h00, 8'h00, a, e, lat, nrd, r0, r1);
      idx_x = 8'h44; operand = 16'h7777; mode = 3'd3;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R11 err flag held", 32'(err), 32'd1);
         chk("R11 addr held after err", 32'(addr_out), 32'd0);
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule